// File: doc/BRIEF.md
# Serial Configuration Port with Staged Register Updates

This block is a three-wire serial slave that gives a host access to a byte-wide configuration register file. The host uses a serial clock, an active-low select and a single data line. The block oversamples all three pins with the system clock. Each frame opens with a 16-bit instruction that carries the direction, the length of the transfer and a 13-bit start address. Data bytes follow. On a write, each byte goes into the register file. On a read, the block turns the data line around and shifts out register contents.

Most registers are held twice, as a shadow copy and as an active copy. A write changes only the shadow copy. The active copies, which drive the block's configuration outputs, all change together when the host sets the transfer bit. A few control registers bypass this staging and act at once. These are the port configuration, the two channel-index bytes and the transfer register itself.

The data line appears as three separate signals: the sampled input, the output value and an output enable. A pad cell outside the block combines them.

Top module: `cfg_spi_regfile`

## Requirements
- R1: After reset, register 0x09 holds 0x01 and the duty-cycle-stabilizer enable output is 1. Every other buffered register is 0 in both its shadow and active copies. The channel-index bytes are 0, LSB-first mode is off and the data output enable is low.
- R2: A frame starts with the first serial-clock rise while select is low. The 16-bit instruction is always sent most significant bit first. Its first bit is the direction (1 = read, 0 = write), the next two bits are the length code, and the last 13 bits are the start address.
- R3: Length codes 00, 01 and 10 move 1, 2 and 3 data bytes. The address steps up by one after each byte. When the count is used up, the next bits are decoded as a new instruction.
- R4: Length code 11 is a streaming transfer. The address keeps stepping up by one per byte until select goes high at a byte boundary, which ends the frame.
- R5: If select goes high while a byte is only partly shifted in, the partial byte is discarded. No register changes, and the next bits after select falls again are decoded as a new instruction.
- R6: In a counted transfer, select may go high and low again between whole bytes. The transfer then resumes with the next byte at the next address.
- R7: In a read frame, the output enable rises after the last instruction bit and stays high while select is low in the data phase. Each data bit is valid on the data output before the serial-clock rise that completes it. The bytes are the shadow contents for buffered registers and the stored value for the others.
- R8: A write to a buffered register (0x08 to 0x22) changes its shadow copy, which read-back shows. The active copy and the configuration outputs do not change.
- R9: Writing a byte with bit 0 set to register 0xFF copies every shadow register into its active copy in one step. The transfer bit then clears itself, so a later read of 0xFF returns 0.
- R10: Registers 0x00, 0x04 and 0x05 have no staging. A write shows on their outputs as soon as the frame ends, with no transfer.
- R11: Bit 6 of register 0x00 selects LSB-first mode. In that mode, data bytes in both directions are shifted least significant bit first. The instruction stays most significant bit first.
- R12: Writes to addresses that are not mapped change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select from the host |
| sdio_in | input | 1 | Data line value seen at the pad |
| sdio_out | output | 1 | Data line value driven during read-back |
| sdio_oe | output | 1 | Pad output enable for the data line |
| lsb_first | output | 1 | LSB-first mode, bit 6 of register 0x00 |
| dcs_enable | output | 1 | Bit 0 of the active copy of register 0x09 |
| chan_idx_a | output | 8 | Register 0x04 (unstaged) |
| chan_idx_b | output | 8 | Register 0x05 (unstaged) |
| active_cfg | output | 216 | Active copies of 0x08..0x22; byte n holds address 0x08+n |

## Verification
The assertions assume that the serial clock and select change slowly next to the system clock. Each level must be held for more than the synchronizer depth plus one cycle, so that no serial-clock rise is missed or counted twice and two byte completions never fall on adjacent cycles. They also assume that the data input is stable while a rise passes through the synchronizer. The bench keeps within this by holding every serial level for six system clocks. It also changes the data line half a serial period before each rise and raises or lowers select only while the serial clock is low.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

  localparam int INSTR_W = 16;
  localparam int ADDR_W  = INSTR_W - 3;

  typedef enum logic {
    PH_INSTR = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;

  localparam logic [1:0] LEN_STREAM = 2'b11;

  // Shift one received bit into a byte in the selected order.
  function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic bit_in,
                                          input logic lsb);
    return lsb ? {bit_in, cur[7:1]} : {cur[6:0], bit_in};
  endfunction

  // Bit of a byte sent at serial position idx (0 = first bit on the wire).
  function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] idx,
                                    input logic lsb);
    return lsb ? b[idx] : b[3'd7 - idx];
  endfunction

  // Number of data bytes for a counted length code, minus one.
  function automatic logic [1:0] bytes_left_init(input logic [1:0] code);
    return code;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W       = 3,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe_q[k] <= RST_VAL;
    end else begin
      pipe_q[0] <= din;
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import cfg_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic              lsb_first,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sdo,
  output logic              sdo_oe
);

  phase_e            phase;
  logic              sclk_d;
  logic [2:0]        bit_cnt;
  logic              instr_hi_done;
  logic [7:0]        sh;
  logic [7:0]        instr_hi;
  logic              rw;
  logic [1:0]        len_code;
  logic [1:0]        left;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        out_byte;

  // Named internal events.
  logic              rise_evt, bit_evt, byte_done, instr_done, data_done;
  logic              abort_evt, stream_end_evt, count_end;
  logic [7:0]        sh_next;
  logic [INSTR_W-1:0] instr_word;

  assign rise_evt       = sclk_s & ~sclk_d;
  assign bit_evt        = rise_evt & ~csn_s;
  assign byte_done      = bit_evt && (bit_cnt == 3'd7);
  assign abort_evt      = csn_s && (bit_cnt != 3'd0);
  assign stream_end_evt = csn_s && (bit_cnt == 3'd0) && (phase == PH_DATA) &&
                          (len_code == LEN_STREAM);
  assign sh_next        = shift_in(sh, sdi_s, lsb_first && (phase == PH_DATA));
  assign instr_word     = {instr_hi, sh_next};
  assign instr_done     = byte_done && (phase == PH_INSTR) && instr_hi_done;
  assign data_done      = byte_done && (phase == PH_DATA);
  assign count_end      = (len_code != LEN_STREAM) && (left == 2'd0);

  assign rd_addr = instr_done ? instr_word[ADDR_W-1:0] : addr + ADDR_W'(1);
  assign wr_stb  = data_done && !rw;
  assign wr_addr = addr;
  assign wr_data = sh_next;
  assign sdo_oe  = (phase == PH_DATA) && rw && !csn_s;
  assign sdo     = pick_bit(out_byte, bit_cnt, lsb_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_INSTR;
      bit_cnt       <= '0;
      instr_hi_done <= 1'b0;
      sh            <= '0;
      instr_hi      <= '0;
      rw            <= 1'b0;
      len_code      <= '0;
      left          <= '0;
      addr          <= '0;
      out_byte      <= '0;
    end else if (abort_evt) begin
      phase         <= PH_INSTR;
      bit_cnt       <= '0;
      instr_hi_done <= 1'b0;
      sh            <= '0;
    end else if (stream_end_evt) begin
      phase         <= PH_INSTR;
      instr_hi_done <= 1'b0;
    end else if (bit_evt) begin
      sh      <= sh_next;
      bit_cnt <= bit_cnt + 3'd1;
      if (byte_done) begin
        if (phase == PH_INSTR) begin
          if (!instr_hi_done) begin
            instr_hi      <= sh_next;
            instr_hi_done <= 1'b1;
          end else begin
            rw            <= instr_word[INSTR_W-1];
            len_code      <= instr_word[INSTR_W-2:INSTR_W-3];
            left          <= bytes_left_init(instr_word[INSTR_W-2:INSTR_W-3]);
            addr          <= instr_word[ADDR_W-1:0];
            phase         <= PH_DATA;
            instr_hi_done <= 1'b0;
            out_byte      <= rd_data;
          end
        end else begin
          addr     <= addr + ADDR_W'(1);
          out_byte <= rd_data;
          if (count_end) begin
            phase <= PH_INSTR;
          end else if (len_code != LEN_STREAM) begin
            left <= left - 2'd1;
          end
        end
      end
    end
  end

  // Checks placed next to the frame logic.
  assert_abort_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (bit_cnt == 3'd0) && (phase == PH_INSTR) && !sdo_oe);

  assert_read_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && instr_word[INSTR_W-1] && !csn_s) |=> sdo_oe);

  assert_addr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |=> (addr == $past(addr) + ADDR_W'(1)));

  assert_stream_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stream_end_evt |=> (phase == PH_INSTR) && !sdo_oe && !wr_stb);

  assert_no_write_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !wr_stb);

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_spi_pkg::*;
#(
  parameter int BUF_FIRST = 8'h08,
  parameter int BUF_LAST  = 8'h22,
  parameter int CFG_ADDR  = 8'h00,
  parameter int IDXA_ADDR = 8'h04,
  parameter int IDXB_ADDR = 8'h05,
  parameter int XFER_ADDR = 8'hFF,
  parameter int DCS_ADDR  = 8'h09,
  parameter logic [7:0] DCS_RST = 8'h01,
  parameter int LSB_BIT   = 6,
  localparam int NUM_BUF  = BUF_LAST - BUF_FIRST + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [7:0]           rd_data,
  output logic                 lsb_first,
  output logic                 dcs_enable,
  output logic [7:0]           idx_a,
  output logic [7:0]           idx_b,
  output logic [NUM_BUF*8-1:0] active_flat
);

  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_IDXA = ADDR_W'(IDXA_ADDR);
  localparam logic [ADDR_W-1:0] A_IDXB = ADDR_W'(IDXB_ADDR);
  localparam logic [ADDR_W-1:0] A_XFER = ADDR_W'(XFER_ADDR);
  localparam int DCS_IDX = DCS_ADDR - BUF_FIRST;

  logic [NUM_BUF-1:0][7:0] shadow_q;
  logic [NUM_BUF-1:0][7:0] active_q;
  logic [7:0]              cfg_q, idxa_q, idxb_q;
  logic                    xfer_pend;
  logic                    copy_evt;
  logic                    buf_hit;

  assign copy_evt = xfer_pend;

  always_comb begin
    buf_hit = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (wr_addr == ADDR_W'(BUF_FIRST + i)) buf_hit = 1'b1;
    end
  end

  // One shadow/active pair per buffered register.
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BUF_FIRST + i);
    localparam logic [7:0]        MY_RST  = (BUF_FIRST + i == DCS_ADDR) ? DCS_RST : 8'h00;
    logic [7:0] sh_r, act_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_r  <= MY_RST;
        act_r <= MY_RST;
      end else begin
        if (wr_stb && (wr_addr == MY_ADDR)) sh_r <= wr_data;
        if (copy_evt) act_r <= sh_r;
      end
    end
    assign shadow_q[i] = sh_r;
    assign active_q[i] = act_r;
  end

  // Unstaged registers and the self-clearing transfer bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      idxa_q    <= '0;
      idxb_q    <= '0;
      xfer_pend <= 1'b0;
    end else begin
      if (wr_stb && (wr_addr == A_CFG))  cfg_q  <= wr_data;
      if (wr_stb && (wr_addr == A_IDXA)) idxa_q <= wr_data;
      if (wr_stb && (wr_addr == A_IDXB)) idxb_q <= wr_data;
      xfer_pend <= wr_stb && (wr_addr == A_XFER) && wr_data[0];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == A_CFG)       rd_data = cfg_q;
    else if (rd_addr == A_IDXA) rd_data = idxa_q;
    else if (rd_addr == A_IDXB) rd_data = idxb_q;
    else if (rd_addr == A_XFER) rd_data = {7'b0, xfer_pend};
    else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (rd_addr == ADDR_W'(BUF_FIRST + i)) rd_data = shadow_q[i];
      end
    end
  end

  assign lsb_first   = cfg_q[LSB_BIT];
  assign idx_a       = idxa_q;
  assign idx_b       = idxb_q;
  assign dcs_enable  = active_q[DCS_IDX][0];
  assign active_flat = active_q;

  // Checks placed next to the staging logic.
  assert_active_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_evt |=> $stable(active_q));

  assert_copy_takes_shadow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt |=> (active_q == $past(shadow_q)));

  assert_xfer_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pend |=> !xfer_pend);

  assert_unmapped_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !buf_hit) |=> $stable(shadow_q));

endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
  import cfg_spi_pkg::*;
#(
  parameter int BUF_FIRST   = 8'h08,
  parameter int BUF_LAST    = 8'h22,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_BUF    = BUF_LAST - BUF_FIRST + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sclk,
  input  logic                 spi_csn,
  input  logic                 sdio_in,
  output logic                 sdio_out,
  output logic                 sdio_oe,
  output logic                 lsb_first,
  output logic                 dcs_enable,
  output logic [7:0]           chan_idx_a,
  output logic [7:0]           chan_idx_b,
  output logic [NUM_BUF*8-1:0] active_cfg
);

  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [7:0]        rd_data, wr_data;
  logic              wr_stb;

  spi_pin_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({spi_sclk, spi_csn, sdio_in}),
    .dout  (pins_s)
  );

  spi_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[2]),
    .csn_s     (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .lsb_first (lsb_first),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sdo       (sdio_out),
    .sdo_oe    (sdio_oe)
  );

  cfg_regbank #(
    .BUF_FIRST (BUF_FIRST),
    .BUF_LAST  (BUF_LAST)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .lsb_first   (lsb_first),
    .dcs_enable  (dcs_enable),
    .idx_a       (chan_idx_a),
    .idx_b       (chan_idx_b),
    .active_flat (active_cfg)
  );

endmodule

// File: tb/cfg_spi_regfile_test.sv
module cfg_spi_regfile_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6 * CLK_PERIOD;
  localparam int NBUF       = 27;

  logic clk = 1'b0;
  logic rst_n, spi_sclk, spi_csn, sdio_in;
  logic sdio_out, sdio_oe, lsb_first, dcs_enable;
  logic [7:0] chan_idx_a, chan_idx_b;
  logic [NBUF*8-1:0] active_cfg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit tb_lsb = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_spi_regfile uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .lsb_first(lsb_first), .dcs_enable(dcs_enable),
    .chan_idx_a(chan_idx_a), .chan_idx_b(chan_idx_b), .active_cfg(active_cfg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] act_byte(input int a);
    return active_cfg[(a-8)*8 +: 8];
  endfunction

  task automatic sel_low();
    spi_csn = 1'b0;
    #(HALF);
  endtask

  task automatic sel_high();
    #(HALF);
    spi_csn = 1'b1;
    #(4*HALF);
  endtask

  task automatic xfer_byte(input logic [7:0] tx, input bit lsb, output logic [7:0] rx,
                           output bit oe_seen);
    oe_seen = 1'b1;
    rx = 8'h00;
    for (int k = 0; k < 8; k++) begin
      int idx;
      idx = lsb ? k : 7 - k;
      sdio_in = tx[idx];
      #(HALF);
      rx[idx] = sdio_out;
      if (!sdio_oe) oe_seen = 1'b0;
      spi_sclk = 1'b1;
      #(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic partial_bits(input int n);
    for (int k = 0; k < n; k++) begin
      sdio_in = 1'b1;
      #(HALF);
      spi_sclk = 1'b1;
      #(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic send_instr(input bit rd, input logic [1:0] len, input logic [12:0] a);
    logic [15:0] w;
    logic [7:0] dummy;
    bit oe;
    w = {rd, len, a};
    xfer_byte(w[15:8], 1'b0, dummy, oe);
    xfer_byte(w[7:0], 1'b0, dummy, oe);
  endtask

  task automatic write1(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] rx;
    bit oe;
    sel_low();
    send_instr(1'b0, 2'b00, a);
    xfer_byte(d, tb_lsb, rx, oe);
    sel_high();
  endtask

  task automatic read1(input logic [12:0] a, output logic [7:0] d, output bit oe);
    sel_low();
    send_instr(1'b1, 2'b00, a);
    xfer_byte(8'h00, tb_lsb, d, oe);
    sel_high();
  endtask

  task automatic t_reset();
    logic [NBUF*8-1:0] exp;
    logic [7:0] r;
    bit oe;
    exp = '0;
    exp[8] = 1'b1;
    check("R1 oe", sdio_oe, 0);
    check("R1 dcs", dcs_enable, 1);
    check("R1 lsb", lsb_first, 0);
    check("R1 idx", {chan_idx_a, chan_idx_b}, 0);
    check("R1 active", (active_cfg == exp), 1);
    read1(13'h009, r, oe);
    check("R1 R7 read 0x09", r, 8'h01);
    check("R7 oe during read", oe, 1);
  endtask

  task automatic t_direct();
    write1(13'h004, 8'hA5);
    check("R10 R2 idx_a", chan_idx_a, 8'hA5);
    check("R7 oe low after write", sdio_oe, 0);
  endtask

  task automatic t_counted();
    logic [7:0] rx;
    bit oe;
    sel_low();
    send_instr(1'b0, 2'b10, 13'h00A);
    xfer_byte(8'h11, 1'b0, rx, oe);
    xfer_byte(8'h22, 1'b0, rx, oe);
    xfer_byte(8'h33, 1'b0, rx, oe);
    // count used up: the next bits form a new instruction in the same frame
    send_instr(1'b0, 2'b00, 13'h005);
    xfer_byte(8'h5C, 1'b0, rx, oe);
    sel_high();
    check("R3 next instr in frame", chan_idx_b, 8'h5C);
    check("R8 active 0x0A held", {act_byte(10), act_byte(11), act_byte(12)}, 0);
    sel_low();
    send_instr(1'b1, 2'b10, 13'h00A);
    xfer_byte(8'h00, 1'b0, rx, oe);
    check("R3 R8 rd 0x0A", rx, 8'h11);
    xfer_byte(8'h00, 1'b0, rx, oe);
    check("R3 rd 0x0B", rx, 8'h22);
    xfer_byte(8'h00, 1'b0, rx, oe);
    check("R3 rd 0x0C", rx, 8'h33);
    check("R7 oe over 3 bytes", oe, 1);
    sel_high();
  endtask

  task automatic t_transfer();
    logic [7:0] r;
    bit oe;
    write1(13'h0FF, 8'h01);
    check("R9 active 0x0A..0C", {act_byte(10), act_byte(11), act_byte(12)}, 24'h112233);
    read1(13'h0FF, r, oe);
    check("R9 xfer self clears", r, 8'h00);
  endtask

  task automatic t_pause();
    logic [7:0] rx;
    bit oe;
    sel_low();
    send_instr(1'b0, 2'b01, 13'h004);
    xfer_byte(8'h5A, 1'b0, rx, oe);
    sel_high();
    sel_low();
    xfer_byte(8'h3C, 1'b0, rx, oe);
    sel_high();
    check("R6 idx_a", chan_idx_a, 8'h5A);
    check("R6 idx_b after pause", chan_idx_b, 8'h3C);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    bit oe;
    sel_low();
    partial_bits(5);
    sel_high();
    write1(13'h005, 8'h77);
    check("R5 instr abort", chan_idx_b, 8'h77);
    check("R5 idx_a kept", chan_idx_a, 8'h5A);
    sel_low();
    send_instr(1'b0, 2'b00, 13'h004);
    partial_bits(4);
    sel_high();
    check("R5 data abort no write", chan_idx_a, 8'h5A);
    read1(13'h004, r, oe);
    check("R5 read after abort", r, 8'h5A);
  endtask

  task automatic t_stream();
    logic [7:0] rx;
    bit oe;
    sel_low();
    send_instr(1'b0, 2'b11, 13'h010);
    for (int k = 0; k < 4; k++) xfer_byte(8'hA1 + 8'(k), 1'b0, rx, oe);
    sel_high();
    check("R8 stream active held", {act_byte(16), act_byte(17), act_byte(18), act_byte(19)}, 0);
    sel_low();
    send_instr(1'b1, 2'b11, 13'h010);
    for (int k = 0; k < 4; k++) begin
      xfer_byte(8'h00, 1'b0, rx, oe);
      check("R4 stream read", rx, 8'hA1 + 8'(k));
    end
    sel_high();
    check("R4 oe off after stream end", sdio_oe, 0);
    write1(13'h0FF, 8'h01);
    check("R4 R9 stream active", {act_byte(16), act_byte(17), act_byte(18), act_byte(19)},
          32'hA1A2A3A4);
    check("R4 no overrun", act_byte(20), 0);
  endtask

  task automatic t_lsb();
    logic [7:0] r;
    bit oe;
    write1(13'h000, 8'h40);
    check("R11 R10 lsb on", lsb_first, 1);
    tb_lsb = 1'b1;
    write1(13'h004, 8'h01);
    check("R11 lsb write", chan_idx_a, 8'h01);
    write1(13'h005, 8'hC8);
    check("R11 lsb write b", chan_idx_b, 8'hC8);
    read1(13'h005, r, oe);
    check("R11 lsb read", r, 8'hC8);
    write1(13'h000, 8'h00);
    tb_lsb = 1'b0;
    check("R11 lsb off", lsb_first, 0);
    read1(13'h005, r, oe);
    check("R11 msb read", r, 8'hC8);
  endtask

  task automatic t_unmapped_dcs();
    logic [7:0] r;
    bit oe;
    write1(13'h100, 8'hEE);
    read1(13'h100, r, oe);
    check("R12 unmapped read", r, 0);
    write1(13'h007, 8'hEE);
    read1(13'h007, r, oe);
    check("R12 gap read", r, 0);
    check("R12 outputs kept", {chan_idx_a, chan_idx_b}, 16'h01C8);
    write1(13'h009, 8'h00);
    check("R8 dcs held", dcs_enable, 1);
    write1(13'h0FF, 8'h01);
    check("R9 dcs off", dcs_enable, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    spi_csn = 1'b1;
    spi_sclk = 1'b0;
    sdio_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_direct();
    t_counted();
    t_transfer();
    t_pause();
    t_abort();
    t_stream();
    t_lsb();
    t_unmapped_dcs();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule